// File: doc/BRIEF.md
# Operand Address and Access Unit

This block resolves the second operand of an instruction from a 2-bit addressing mode. An operand can be an immediate constant, a register, or a 32-bit word in memory. A memory operand is found either at a direct address or at an address held in a register. For both memory modes a signed offset value is added to the base, and the sum wraps within a 24-bit byte address space.

A request is a one-cycle `start` pulse that carries the mode, the register selector, the constant/address field and a read or write flag. Register and constant operands finish one cycle after the request. A memory operand moves as four single-byte transfers over a byte-wide memory port, lowest address first, in little-endian order. The start address may be any byte address. `done` pulses once the operand is ready or the write is complete. A request for a write to a constant is rejected with an illegal-operand flag.

Top module: `opnd_access`

## Requirements
- R1: Mode 00 (constant) with a read request returns `field` unchanged on `operand`, with `done` high in the cycle after `start` and no memory cycle.
- R2: Mode 00 with a write request raises `illegal` together with `done` in the cycle after `start`. It makes no memory cycle and no register write.
- R3: Mode 10 (register) makes no memory cycle. A read returns register `rsel` (bits `rsel*32 +: 32` of `regs`) with `done` one cycle after `start`. A write pulses `reg_we` with `done`, with `reg_wsel` = `rsel` and `reg_wdata` = `wdata`.
- R4: Mode 01 (direct) uses the effective address `field[23:0] + ofs`, truncated to 24 bits.
- R5: Mode 11 (register-indirect) uses the effective address `regs[rsel][23:0] + ofs`, truncated to 24 bits. `ofs` is read as a signed 32-bit value, so a negative offset steps the address downward.
- R6: A memory operand puts byte k (k = 0..3) at address `EA + k` mod 2^24 on `mem_addr` in cycle k+1 after `start`. `done` is high in cycle 5.
- R7: A memory read is little endian: the byte at `EA + k` lands in `operand[8k+7:8k]`.
- R8: A memory write drives `wdata[8k+7:8k]` on `mem_wdata` while byte k is addressed.
- R9: `mem_rd` and `mem_wr` are never high together. During a transfer, only the one that matches the request's write flag is high.
- R10: A `start` that arrives while a memory transfer is in progress is ignored. The current address sequence and direction go on unchanged.
- R11: In reset and just after it, `done`, `illegal`, `reg_we`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| wr | input | 1 | 1 = write operand, 0 = read operand |
| mode | input | 2 | Addressing mode: 00 constant, 01 direct, 10 register, 11 register-indirect |
| rsel | input | 3 | Register selector |
| field | input | 32 | Immediate constant or direct address (low 24 bits) |
| ofs | input | 32 | Signed offset added in memory modes |
| regs | input | 256 | Eight 32-bit register values, register i at bits i*32 +: 32 |
| wdata | input | 32 | Value to store |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle as the address |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_wr | output | 1 | Memory byte write strobe |
| mem_wdata | output | 8 | Memory write byte |
| reg_we | output | 1 | Register write strobe |
| reg_wsel | output | 3 | Register written |
| reg_wdata | output | 32 | Register write value |
| operand | output | 32 | Resolved operand value |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Write to a constant was requested |

## Verification
Two events can fall in the same cycle: the completion of one memory transfer (`done` high) and the acceptance of a new `start`. The bench issues a second direct-address read in exactly the `done` cycle of the first read. It then checks that the next cycle already carries the new effective address with `mem_rd` high, and that the second operand completes four cycles later. A separate test pulses `start` in the middle of a transfer and checks that the address sequence and the direction are not disturbed.

// File: rtl/opnd_access.sv
module opnd_access #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int RSW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      wr,
  input  logic [1:0]                mode,
  input  logic [RSW-1:0]            rsel,
  input  logic [DW-1:0]             field,
  input  logic [DW-1:0]             ofs,
  input  logic [(1<<RSW)*DW-1:0]    regs,
  input  logic [DW-1:0]             wdata,
  input  logic [7:0]                mem_rdata,
  output logic [AW-1:0]             mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [7:0]                mem_wdata,
  output logic                      reg_we,
  output logic [RSW-1:0]            reg_wsel,
  output logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             operand,
  output logic                      done,
  output logic                      illegal
);
  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB);

  logic          busy, wr_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wdata_q;

  wire [DW-1:0] rval = regs[rsel*DW +: DW];
  wire [AW-1:0] base = mode[1] ? rval[AW-1:0] : field[AW-1:0];
  wire [AW-1:0] ea   = base + ofs[AW-1:0];
  wire          go   = start & ~busy;

  assign mem_rd    = busy & ~wr_q;
  assign mem_wr    = busy & wr_q;
  assign mem_wdata = wdata_q[{cnt, 3'b000} +: 8];
  assign reg_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      cnt      <= '0;
      mem_addr <= '0;
      wdata_q  <= '0;
      operand  <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      reg_we   <= 1'b0;
      reg_wsel <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      reg_we  <= 1'b0;
      if (go) begin
        wr_q    <= wr;
        wdata_q <= wdata;
        if (mode[0]) begin
          busy     <= 1'b1;
          cnt      <= '0;
          mem_addr <= ea;
        end else begin
          done <= 1'b1;
          if (!mode[1]) begin
            if (wr) illegal <= 1'b1;
            else    operand <= field;
          end else if (wr) begin
            reg_we   <= 1'b1;
            reg_wsel <= rsel;
          end else begin
            operand <= rval;
          end
        end
      end else if (busy) begin
        if (!wr_q) operand[{cnt, 3'b000} +: 8] <= mem_rdata;
        mem_addr <= mem_addr + 1'b1;
        cnt      <= cnt + 1'b1;
        if (cnt == CW'(NB - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module opnd_access_chk #(parameter int AW = 24) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr,
  input logic [1:0]    mode,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          done,
  input logic          illegal,
  input logic          reg_we
);
  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_rd && $past(mem_wr)) || (mem_wr && $past(mem_rd))));

  assert_const_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b00 && wr) |=> (done && illegal && !mem_rd && !mem_wr && !reg_we));

  assert_illegal_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_reg_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b10) |=> (done && !mem_rd && !mem_wr && !illegal));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> mem_addr == AW'($past(mem_addr) + 1'b1));
endmodule

bind opnd_access opnd_access_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .mode(mode), .busy(busy),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done),
  .illegal(illegal), .reg_we(reg_we)
);

// File: tb/sim_opnd_access.sv
module sim_opnd_access;
  localparam int PERIOD = 10;

  logic         clk = 0, rst_n = 0, start = 0, wr = 0;
  logic [1:0]   mode = 0;
  logic [2:0]   rsel = 0;
  logic [31:0]  field = 0, ofs = 0, wdata = 0;
  logic [255:0] regs = 0;
  logic [7:0]   mem_rdata, mem_wdata;
  logic [23:0]  mem_addr;
  logic         mem_rd, mem_wr, reg_we, done, illegal;
  logic [2:0]   reg_wsel;
  logic [31:0]  reg_wdata, operand;
  logic [7:0]   mem [256];
  int nchk = 0, nfail = 0;

  always #(PERIOD/2) clk = ~clk;

  opnd_access u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .mode(mode), .rsel(rsel),
    .field(field), .ofs(ofs), .regs(regs), .wdata(wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .operand(operand), .done(done), .illegal(illegal)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] eff(input logic [1:0] m, input logic [2:0] r,
                                      input logic [31:0] f);
    logic [23:0] b;
    b = m[1] ? regs[r*32 +: 24] : f[23:0];
    return b + ofs[23:0];
  endfunction

  task automatic op(input logic [1:0] m, input logic w, input logic [2:0] r,
                    input logic [31:0] f, input logic [31:0] d, input bit poke);
    logic [23:0] ea;
    logic [31:0] exp_rd;
    ea = eff(m, r, f);
    for (int k = 0; k < 4; k++) exp_rd[8*k +: 8] = mem[8'(ea + 24'(k))];
    @(negedge clk);
    start = 1; mode = m; wr = w; rsel = r; field = f; wdata = d;
    @(negedge clk);
    start = 0;
    if (m[0]) begin
      for (int k = 0; k < 4; k++) begin
        chk(m[1] ? "R5 R6 indirect addr" : "R4 R6 direct addr", 32'(mem_addr), 32'(24'(ea + 24'(k))));
        chk("R9 strobes", {30'd0, mem_rd, mem_wr}, w ? 32'd1 : 32'd2);
        if (w) chk("R8 write byte", 32'(mem_wdata), 32'(d[8*k +: 8]));
        chk("R6 no early done", 32'(done), 0);
        if (poke && k == 1) begin start = 1; mode = 2'b11; wr = ~w; rsel = 3'd5; end
        @(negedge clk);
        start = 0;
      end
      chk("R6 done after 4 bytes", 32'(done), 1);
      chk("R6 strobes idle at done", {30'd0, mem_rd, mem_wr}, 0);
      if (!w) chk("R7 little endian read", operand, exp_rd);
      else for (int k = 0; k < 4; k++)
        chk("R8 stored byte", 32'(mem[8'(ea + 24'(k))]), 32'(d[8*k +: 8]));
    end else begin
      chk(m[1] ? "R3 done" : "R1 done", 32'(done), 1);
      chk(m[1] ? "R3 no mem" : "R1 R2 no mem", {30'd0, mem_rd, mem_wr}, 0);
      if (!m[1] && !w) chk("R1 constant", operand, f);
      if (!m[1] && w) begin
        chk("R2 illegal", 32'(illegal), 1);
        chk("R2 no reg write", 32'(reg_we), 0);
      end
      if (m[1] && !w) chk("R3 reg read", operand, regs[r*32 +: 32]);
      if (m[1] && w) begin
        chk("R3 reg_we", 32'(reg_we), 1);
        chk("R3 reg_wsel", 32'(reg_wsel), 32'(r));
        chk("R3 reg_wdata", reg_wdata, d);
      end
      if (m[1]) chk("R3 not illegal", 32'(illegal), 0);
      @(negedge clk);
      chk("R11 done is a pulse", 32'(done), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] ofs_set [6];
    ofs_set = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'h7FFF_FF00, 32'h0100_0003};
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 8; i++) regs[i*32 +: 32] = {8'hA0 + 8'(i), 24'hFFFFFC + 24'(i)};
    repeat (3) @(negedge clk);
    chk("R11 reset done", 32'(done), 0);
    chk("R11 reset flags", {29'd0, illegal, reg_we, mem_rd || mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 after reset", {28'd0, done, illegal, reg_we, mem_rd || mem_wr}, 0);

    foreach (ofs_set[oi]) begin
      ofs = ofs_set[oi];
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          for (int r = 0; r < 8; r++)
            op(2'(m), 1'(w), 3'(r), {8'h5A, 24'hFFFFF8 + 24'(r)},
               32'hC0DE_0000 ^ (32'(r) * 32'h0101_0101) ^ 32'(w + 4*m), 1'b0);
    end

    ofs = 32'hFFFF_FFFE;
    op(2'b01, 1'b0, 3'd0, 32'h0000_0001, 0, 1'b1);
    op(2'b11, 1'b1, 3'd2, 0, 32'h1234_5678, 1'b1);

    // R6: new request accepted in the done cycle of the previous one
    ofs = 32'h10;
    @(negedge clk);
    start = 1; mode = 2'b01; wr = 0; field = 32'h0000_0040;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk("R6 first done", 32'(done), 1);
    start = 1; mode = 2'b01; wr = 0; field = 32'h00FF_FFF0;
    @(negedge clk);
    start = 0;
    chk("R4 R6 back-to-back addr", 32'(mem_addr), 32'h0000_0000);
    chk("R9 back-to-back read", 32'(mem_rd), 1);
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk("R6 second done", 32'(done), 1);
    chk("R7 second operand", operand, {mem[3], mem[2], mem[1], mem[0]});

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule